// File: doc/BRIEF.md
# Decimal Matrix Code Word Protector

This block guards a 32-bit memory word against multi-bit upsets. The word is treated as eight 4-bit symbols laid out as two logical rows of four columns. When a word is written, the block appends 36 check bits. Twenty are horizontal: in each row the symbols of columns 0 and 2 are added as unsigned integers, and so are the symbols of columns 1 and 3, each giving a 5-bit sum. Sixteen are vertical: for each column the two symbols are XORed bit by bit. The resulting 68-bit codeword goes to the memory, which is outside this block.

When a codeword comes back from memory, the same check generator is run in syndrome mode: it recomputes the sums and column parities from the stored data and returns the integer difference against the stored sums and the XOR against the stored parities. A nonzero sum difference locates the row (and column pair) of a damaged symbol, and the vertical syndrome gives the exact bits to invert. Inconsistent syndromes raise an uncorrectable flag. One request is accepted per cycle and registered; the results appear, combinationally decoded, in the following cycle.

Top module: `dmc_codec`

## Requirements
- R1: While reset is asserted and in the first cycle after it, code_vld, rd_vld, rd_err and rd_unc are 0 and code_out and rd_data are all zeros.
- R2: A write request (wr_en=1) at a clock edge gives code_vld=1 in the next cycle, with code_out[31:0] equal to the written data, the horizontal field f (f=0..3) at code_out[32+5f +: 5] and the vertical field of column c (c=0..3) at code_out[52+4c +: 4].
- R3: Symbol s is data[4s +: 4], lying in row s/4 and column s%4. Horizontal field f = 2*row + p (p=0,1) holds the 5-bit unsigned sum of the symbols at columns p and p+2 of that row.
- R4: The vertical field of column c is the bitwise XOR of symbols c and c+4.
- R5: A read request (rd_en=1 with wr_en=0) gives rd_vld=1 in the next cycle; when the supplied codeword is consistent, rd_err=0, rd_unc=0 and rd_data equals codeword bits [31:0].
- R6: Any contiguous run of 1 to 5 inverted bits within the data bits [31:0] of a valid codeword is corrected: rd_data equals the original data, rd_err=1 and rd_unc=0.
- R7: A codeword whose only damage is in check bits (a horizontal field or a vertical field) gives rd_err=1 and rd_unc=1, and rd_data then equals the stored data bits [31:0] unmodified.
- R8: Identical bit damage in both symbols of one column (cancelling in the vertical syndrome) gives rd_err=1, rd_unc=1 and rd_data equal to the stored (damaged) data bits.
- R9: When wr_en and rd_en are both 1 at an edge, only the write is performed: next cycle code_vld=1 and rd_vld=0.
- R10: In any cycle without a valid result, code_out is all zeros when code_vld=0 and rd_data, rd_err, rd_unc are 0 when rd_vld=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Encode request; wins over rd_en |
| wr_data | input | 32 | Data word to encode |
| rd_en | input | 1 | Decode request |
| rd_code | input | 68 | Codeword read back from memory |
| code_vld | output | 1 | code_out holds a fresh codeword |
| code_out | output | 68 | Encoded word: data, horizontal sums, vertical parities |
| rd_vld | output | 1 | Read results are valid |
| rd_data | output | 32 | Corrected data word |
| rd_err | output | 1 | Some syndrome was nonzero |
| rd_unc | output | 1 | Syndromes could not be resolved; data passed uncorrected |

## Verification
Random data words are encoded and compared against sums and parities computed independently, with all-zero and all-ones words probing the smallest and largest 5-bit sums. Reads of clean codewords separate a correct pass-through from spurious flagging, while random bursts of one to five bits at random positions, including runs that straddle the row boundary at bit 16, show that the row and column syndromes combine to invert exactly the damaged bits. Damage confined to a horizontal or vertical check field, and cancelling damage in the two symbols of one column, are used to show that inconsistent syndromes raise the uncorrectable flag and leave the data untouched rather than miscorrected.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int SYM_W  = 4;
  localparam int ROWS   = 2;
  localparam int COLS   = 4;
  localparam int NSYM   = ROWS * COLS;
  localparam int DATA_W = NSYM * SYM_W;
  localparam int NPAIR  = COLS / 2;
  localparam int HSUM_W = SYM_W + 1;
  localparam int NHF    = ROWS * NPAIR;
  localparam int H_W    = NHF * HSUM_W;
  localparam int V_W    = COLS * SYM_W;
  localparam int H_LSB  = DATA_W;
  localparam int V_LSB  = DATA_W + H_W;
  localparam int CODE_W = DATA_W + H_W + V_W;

  typedef enum logic [1:0] {OP_IDLE, OP_WR, OP_RD} op_e;

  // Unsigned sum of the two symbols of one row that share column parity p.
  function automatic logic [HSUM_W-1:0] pair_sum(input logic [DATA_W-1:0] d,
                                                 input int r, input int p);
    int a;
    int b;
    a = r * COLS + p;
    b = a + NPAIR;
    return HSUM_W'(d[a*SYM_W +: SYM_W]) + HSUM_W'(d[b*SYM_W +: SYM_W]);
  endfunction

  // Bitwise parity of one column across all rows.
  function automatic logic [SYM_W-1:0] col_par(input logic [DATA_W-1:0] d, input int c);
    logic [SYM_W-1:0] acc;
    acc = '0;
    for (int r = 0; r < ROWS; r++) acc ^= d[(r*COLS + c)*SYM_W +: SYM_W];
    return acc;
  endfunction
endpackage

// File: rtl/dmc_encoder.sv
// Shared check generator: plain check bits when en=0, syndromes when en=1.
module dmc_encoder
  import dmc_pkg::*;
(
  input  logic              en,
  input  logic [DATA_W-1:0] data,
  input  logic [H_W-1:0]    h_in,
  input  logic [V_W-1:0]    v_in,
  output logic [H_W-1:0]    h_out,
  output logic [V_W-1:0]    v_out
);
  for (genvar f = 0; f < NHF; f++) begin : g_hsum
    logic [HSUM_W-1:0] fresh;
    assign fresh = pair_sum(data, f / NPAIR, f % NPAIR);
    assign h_out[f*HSUM_W +: HSUM_W] = en ? fresh - h_in[f*HSUM_W +: HSUM_W] : fresh;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_vpar
    logic [SYM_W-1:0] fresh;
    assign fresh = col_par(data, c);
    assign v_out[c*SYM_W +: SYM_W] = fresh ^ (en ? v_in[c*SYM_W +: SYM_W] : '0);
  end
endmodule

// File: rtl/dmc_corrector.sv
module dmc_corrector
  import dmc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [H_W-1:0]    h_store,
  input  logic [H_W-1:0]    syn_h,
  input  logic [V_W-1:0]    syn_v,
  output logic [DATA_W-1:0] data_out,
  output logic              err,
  output logic              unc,
  output logic [NHF-1:0]    hnz,
  output logic [COLS-1:0]   vnz
);
  logic [DATA_W-1:0] corr;
  logic [COLS-1:0]   col_bad;
  logic [NHF-1:0]    pair_bad;
  logic [NHF-1:0]    sum_bad;

  for (genvar f = 0; f < NHF; f++) begin : g_hnz
    assign hnz[f] = |syn_h[f*HSUM_W +: HSUM_W];
  end
  for (genvar c = 0; c < COLS; c++) begin : g_vnz
    assign vnz[c] = |syn_v[c*SYM_W +: SYM_W];
  end

  for (genvar s = 0; s < NSYM; s++) begin : g_fix
    localparam int R = s / COLS;
    localparam int C = s % COLS;
    localparam int F = R * NPAIR + C % NPAIR;
    assign corr[s*SYM_W +: SYM_W] =
      data[s*SYM_W +: SYM_W] ^ (hnz[F] ? syn_v[C*SYM_W +: SYM_W] : '0);
  end

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      int cnt;
      cnt = 0;
      for (int r = 0; r < ROWS; r++)
        if (hnz[r*NPAIR + c%NPAIR]) cnt++;
      col_bad[c] = vnz[c] && (cnt != 1);
    end
    for (int f = 0; f < NHF; f++) begin
      logic any_v;
      any_v = 1'b0;
      for (int c = 0; c < COLS; c++)
        if (c % NPAIR == f % NPAIR) any_v = any_v | vnz[c];
      pair_bad[f] = hnz[f] && !any_v;
      sum_bad[f]  = hnz[f] &&
                    (pair_sum(corr, f / NPAIR, f % NPAIR) != h_store[f*HSUM_W +: HSUM_W]);
    end
  end

  assign err      = (|hnz) | (|vnz);
  assign unc      = (|col_bad) | (|pair_bad) | (|sum_bad);
  assign data_out = unc ? data : corr;
endmodule

// File: rtl/dmc_codec.sv
module dmc_codec
  import dmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [67:0]       rd_code,
  output logic              code_vld,
  output logic [67:0]       code_out,
  output logic              rd_vld,
  output logic [31:0]       rd_data,
  output logic              rd_err,
  output logic              rd_unc
);
  op_e               op_q;
  logic [CODE_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      hold_q <= '0;
    end else if (wr_en) begin
      op_q   <= OP_WR;
      hold_q <= {{(H_W+V_W){1'b0}}, wr_data};
    end else if (rd_en) begin
      op_q   <= OP_RD;
      hold_q <= rd_code;
    end else begin
      op_q   <= OP_IDLE;
    end
  end

  // Named internal events for the checker.
  logic              enc_en;
  logic [H_W-1:0]    chk_h;
  logic [V_W-1:0]    chk_v;
  logic [NHF-1:0]    hnz;
  logic [COLS-1:0]   vnz;
  logic [DATA_W-1:0] cor_data;
  logic              cor_err;
  logic              cor_unc;

  assign enc_en = (op_q == OP_RD);

  dmc_encoder u_enc (
    .en    (enc_en),
    .data  (hold_q[DATA_W-1:0]),
    .h_in  (hold_q[H_LSB +: H_W]),
    .v_in  (hold_q[V_LSB +: V_W]),
    .h_out (chk_h),
    .v_out (chk_v)
  );

  dmc_corrector u_cor (
    .data     (hold_q[DATA_W-1:0]),
    .h_store  (hold_q[H_LSB +: H_W]),
    .syn_h    (chk_h),
    .syn_v    (chk_v),
    .data_out (cor_data),
    .err      (cor_err),
    .unc      (cor_unc),
    .hnz      (hnz),
    .vnz      (vnz)
  );

  assign code_vld = (op_q == OP_WR);
  assign rd_vld   = enc_en;
  assign code_out = code_vld ? {chk_v, chk_h, hold_q[DATA_W-1:0]} : '0;
  assign rd_data  = rd_vld ? cor_data : '0;
  assign rd_err   = rd_vld & cor_err;
  assign rd_unc   = rd_vld & cor_unc;
endmodule

// File: rtl/dmc_codec_chk.sv
module dmc_codec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        rd_en,
  input logic [67:0] rd_code,
  input logic        code_vld,
  input logic [67:0] code_out,
  input logic        rd_vld,
  input logic [31:0] rd_data,
  input logic        rd_err,
  input logic        rd_unc,
  input logic [3:0]  hnz,
  input logic [3:0]  vnz
);
  p_wr_then_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> code_vld && code_out[31:0] == $past(wr_data));

  p_rd_then_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en |=> rd_vld);

  p_clean_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld && !rd_err |-> rd_data == $past(rd_code[31:0]));

  p_unc_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unc |-> rd_err && rd_data == $past(rd_code[31:0]));

  p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_en |=> !rd_vld);

  p_quiet_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !code_vld |-> code_out == '0);

  p_quiet_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld |-> rd_data == '0 && !rd_err && !rd_unc);

  p_syn_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld && (hnz != '0 || vnz != '0) |-> rd_err);
endmodule

bind dmc_codec dmc_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .rd_code(rd_code), .code_vld(code_vld), .code_out(code_out), .rd_vld(rd_vld),
  .rd_data(rd_data), .rd_err(rd_err), .rd_unc(rd_unc), .hnz(hnz), .vnz(vnz)
);

// File: tb/tb_dmc_codec.sv
`timescale 1ns/1ps
module tb_dmc_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [67:0] rd_code = '0;
  logic        code_vld;
  logic [67:0] code_out;
  logic        rd_vld;
  logic [31:0] rd_data;
  logic        rd_err;
  logic        rd_unc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmc_codec dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_code(rd_code), .code_vld(code_vld), .code_out(code_out), .rd_vld(rd_vld),
    .rd_data(rd_data), .rd_err(rd_err), .rd_unc(rd_unc)
  );

  // Reference encoder written from R2..R4.
  function automatic logic [67:0] ref_code(input logic [31:0] d);
    logic [67:0] cw;
    cw = '0;
    cw[31:0] = d;
    for (int f = 0; f < 4; f++) begin
      int base;
      int sa;
      int sb;
      base = (f / 2) * 4 + (f % 2);
      sa = int'((d >> (4 * base)) & 32'hF);
      sb = int'((d >> (4 * (base + 2))) & 32'hF);
      cw[32 + 5*f +: 5] = 5'(sa + sb);
    end
    for (int i = 0; i < 16; i++) cw[52 + i] = d[i] ^ d[i + 16];
    return cw;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [67:0] act,
                     input logic [67:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d, input string req);
    logic [67:0] e;
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    e = ref_code(d);
    chk(code_vld === 1'b1 && rd_vld === 1'b0, {req, " vld"}, {66'd0, code_vld, rd_vld}, 68'd2);
    chk(code_out === e, req, code_out, e);
  endtask

  task automatic do_read(input logic [67:0] cw, input logic [31:0] exp_d,
                         input bit exp_err, input bit exp_unc, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_code = cw;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_vld === 1'b1 && code_vld === 1'b0, {req, " vld"}, {66'd0, rd_vld, code_vld}, 68'd2);
    chk(rd_data === exp_d, {req, " data"}, {36'd0, rd_data}, {36'd0, exp_d});
    chk(rd_err === exp_err && rd_unc === exp_unc, {req, " flags"},
        {66'd0, rd_err, rd_unc}, {66'd0, exp_err, exp_unc});
  endtask

  initial begin
    logic [31:0] d;
    logic [67:0] cw;
    void'($urandom(32'd4242));
    // R1: reset state
    #2;
    chk(code_vld === 1'b0 && rd_vld === 1'b0 && rd_err === 1'b0 && rd_unc === 1'b0,
        "R1 flags in reset", {64'd0, code_vld, rd_vld, rd_err, rd_unc}, 68'd0);
    chk(code_out === '0 && rd_data === '0, "R1 data in reset", code_out, 68'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(code_vld === 1'b0 && rd_vld === 1'b0 && code_out === '0, "R1 after reset",
        code_out, 68'd0);

    // R2 R3 R4: directed and random encoding
    do_write(32'h0000_0000, "R3 zero word");
    do_write(32'hFFFF_FFFF, "R3 max sums");
    do_write(32'hF5AF_F6AC, "R4 mixed word");
    for (int i = 0; i < 300; i++) do_write($urandom, "R2 random encode");

    // R10: idle cycle after a write
    @(negedge clk);
    chk(code_out === '0 && rd_data === '0 && rd_err === 1'b0, "R10 idle outputs",
        code_out, 68'd0);

    // R5: clean reads
    do_read(ref_code(32'h0000_0000), 32'h0000_0000, 1'b0, 1'b0, "R5 clean zero");
    for (int i = 0; i < 100; i++) begin
      d = $urandom;
      do_read(ref_code(d), d, 1'b0, 1'b0, "R5 clean random");
    end

    // R6: bursts of 1..5 bits in the data field
    for (int i = 0; i < 400; i++) begin
      int len;
      int st;
      logic [31:0] m;
      d   = $urandom;
      len = 1 + int'($urandom % 5);
      st  = int'($urandom % (33 - len));
      m   = ((32'd1 << len) - 32'd1) << st;
      cw  = ref_code(d);
      cw[31:0] = cw[31:0] ^ m;
      do_read(cw, d, 1'b1, 1'b0, "R6 burst");
    end
    d = 32'h1234_5678;
    cw = ref_code(d);
    cw[18:14] = ~cw[18:14];
    do_read(cw, d, 1'b1, 1'b0, "R6 burst across rows");

    // R7: damage in check bits only
    d = 32'hA5C3_0F96;
    cw = ref_code(d); cw[32] = ~cw[32];
    do_read(cw, d, 1'b1, 1'b1, "R7 horizontal field hit");
    cw = ref_code(d); cw[52] = ~cw[52];
    do_read(cw, d, 1'b1, 1'b1, "R7 vertical field hit");

    // R8: same bit of both symbols in column 0 (bits 0 and 16)
    d = 32'h0F0F_3C3C;
    cw = ref_code(d); cw[0] = ~cw[0]; cw[16] = ~cw[16];
    do_read(cw, cw[31:0], 1'b1, 1'b1, "R8 column cancel");

    // R9: both requests in one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'hDEAD_BEEF; rd_en = 1'b1; rd_code = ref_code(32'h1);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(code_vld === 1'b1 && rd_vld === 1'b0, "R9 write wins",
        {66'd0, code_vld, rd_vld}, 68'd2);
    chk(code_out === ref_code(32'hDEAD_BEEF), "R9 write result", code_out,
        ref_code(32'hDEAD_BEEF));
    @(negedge clk);
    chk(rd_vld === 1'b0 && rd_data === '0 && rd_unc === 1'b0, "R10 idle read side",
        {36'd0, rd_data}, 68'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule